// File: doc/BRIEF.md
# Dual-Register Capture/Compare Timer Channel

This block is one timer channel built around two data registers, A and B, that share a single pin. A control register picks one of four external counter buses, an edge polarity, a PWM resolution and an encoded mode. In the input modes the channel records counter values when edges arrive on the pin. In the output modes it drives the pin from matches between the counter and A and B. A sticky flag tells software that a capture or a qualifying match has happened.

Software reaches the channel through a simple register port. Writes are single-cycle and reads are combinational. Four word addresses are decoded: 0 is control, 1 is A, 2 is B and 3 is status. Control bits [3:0] hold the mode and bits [5:4] the bus select. Bit 6 sets edge polarity (0 means a rising edge is the selected edge, 1 a falling edge). Bit 7 is the high resolution-select bit. Bits above 7 read as zero. Status reads back bit 0 as the flag and bit 1 as the synchronized pin level. Writing status with bit 0 set clears the flag.

Mode encodings: 0000 disabled, 0001 pulse width, 0010 period, 0011 input capture, 0100 compare with the flag raised on B, 0101 compare with the flag raised on A and B, and 1xxx PWM. The codes 0110 and 0111 behave like disabled for the pin and for captures.

Top module: `dual_reg_timer_chan`

## Requirements
- R1: Every capture and compare uses the counter bus chosen by control bits [5:4]. The chosen bus value is registered once before use.
- R2: In disabled mode the pin driver is off and the flag stays 0. Pin edges change neither A nor B. The status PIN bit follows the pin input two clock edges after it changes.
- R3: In disabled mode, control (bits [7:0]), A and B can all be written and read back unchanged.
- R4: In pulse-width mode the leading edge is the selected polarity and its counter value is held internally. The opposite (trailing) edge loads A with the held value and B with the trailing counter value in the same cycle, and sets the flag. A and B do not change on the leading edge.
- R5: In period mode, each pair of consecutive selected edges loads A with the first counter value and B with the second, and sets the flag. Edges of the opposite polarity are ignored.
- R6: In input-capture mode, each selected edge loads B with the counter value and sets the flag. A is left unchanged.
- R7: In both compare modes the pin driver is on. The pin goes high when the counter equals A and low when it equals B. When both match in the same cycle, B wins. The pin changes two clock edges after the counter bus.
- R8: Mode 0100 sets the flag only on a B match. Mode 0101 sets it on an A match or a B match.
- R9: PWM mode masks the counter to N low bits. The resolution index is {control bit 7, mode bits [1:0]}, and indices 0..7 give N = 7, 9, 11, 12, 13, 14, 15, 16. The pin goes high when the masked count equals A and low when it equals B.
- R10: In PWM mode, writes to A and B reach the compare only after the masked counter has been all ones (the period rollover).
- R11: The flag is sticky. A write of 1 to status bit 0 clears it, and so does any control write with mode 0000. A capture or match event in the same cycle as a status clear wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_bus_i | input | 64 | Four 16-bit counter buses, bus k in bits [16k+15:16k] |
| pin_i | input | 1 | Pin input level |
| pin_o | output | 1 | Pin output level |
| pin_oe_o | output | 1 | Pin driver enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 16 | Register read data |
| flag_o | output | 1 | Sticky event flag |
| pin_status_o | output | 1 | Synchronized pin level |

## Verification
The hardest case to reach from the ports is PWM double buffering. To show that a new A value is held back, the bench must move the counter onto the new value without crossing the all-ones point of the masked range. It then reaches the pin transition only by passing through that point. The bench holds the counter buses at chosen values, puts high bits outside the mask into the counter, and picks random resolutions. It then walks the counter through pending-value, rollover and match points in a fixed order. Captures use randomly chosen buses and polarities. The counter is held still around each pin edge, so the expected register values are exact.

// File: rtl/tcc_pkg.sv
// Shared constants for the dual-register timer channel: mode codes,
// register addresses and the PWM resolution table.
package tcc_pkg;
    localparam logic [3:0] MODE_DIS  = 4'b0000;
    localparam logic [3:0] MODE_PW   = 4'b0001;
    localparam logic [3:0] MODE_PER  = 4'b0010;
    localparam logic [3:0] MODE_IC   = 4'b0011;
    localparam logic [3:0] MODE_OCB  = 4'b0100;
    localparam logic [3:0] MODE_OCAB = 4'b0101;

    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_A    = 2'd1;
    localparam logic [1:0] ADDR_B    = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    // Resolution in bits for index 0..7: 7, 9, 11, 12, 13, 14, 15, 16.
    function automatic int res_bits(input logic [2:0] idx);
        int i;
        i = int'(idx);
        return (i < 3) ? (7 + 2 * i) : (9 + i);
    endfunction
endpackage

// File: rtl/tcc_bus_sel.sv
// Counter bus selector: picks one of NUM_BUSES counter buses and registers it.
// Assumes the buses are already synchronous to clk.
module tcc_bus_sel #(
    parameter int CNT_W     = 16,
    parameter int NUM_BUSES = 4,
    localparam int SEL_W    = (NUM_BUSES > 1) ? $clog2(NUM_BUSES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BUSES*CNT_W-1:0] bus_i,
    input  logic [SEL_W-1:0]           sel_i,
    output logic [CNT_W-1:0]           cnt_o
);
    logic [CNT_W-1:0] lane [NUM_BUSES];

    for (genvar g = 0; g < NUM_BUSES; g++) begin : g_lane
        assign lane[g] = bus_i[g*CNT_W +: CNT_W];
    end

    // Register the selected bus value.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_o <= '0;
        else        cnt_o <= lane[sel_i];
    end
endmodule

// File: rtl/tcc_pin_sync.sv
// Pin synchronizer and edge detector. The pin passes through STAGES flops;
// an edge is an inequality between the last two synchronized samples.
// Assumes STAGES >= 2.
module tcc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic level_o,
    output logic sel_edge_o,
    output logic opp_edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic              rise, fall;

    // Shift the pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_i};
    end

    // Keep the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    // Classify the edge by polarity.
    always_comb begin
        level_o    = sync_q[STAGES-1];
        rise       = level_o & ~prev_q;
        fall       = ~level_o & prev_q;
        sel_edge_o = fall_sel_i ? fall : rise;
        opp_edge_o = fall_sel_i ? rise : fall;
    end
endmodule

// File: rtl/tcc_capture.sv
// Capture engine for the three input modes. It outputs write strobes and
// values for A and B plus an event pulse. The top owns the registers.
// Assumes the edge inputs are single-cycle pulses.
module tcc_capture
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode_i,
    input  logic             sel_edge_i,
    input  logic             opp_edge_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             a_we_o,
    output logic             b_we_o,
    output logic [CNT_W-1:0] a_val_o,
    output logic [CNT_W-1:0] b_val_o,
    output logic             evt_o
);
    logic [CNT_W-1:0] hold_q;
    logic             armed_q;

    // Track the first edge of a measurement and hold its counter value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            case (mode_i)
                MODE_PW: begin
                    if (!armed_q && sel_edge_i) begin
                        hold_q  <= cnt_i;
                        armed_q <= 1'b1;
                    end else if (armed_q && opp_edge_i) begin
                        armed_q <= 1'b0;
                    end
                end
                MODE_PER: begin
                    if (sel_edge_i) begin
                        hold_q  <= cnt_i;
                        armed_q <= 1'b1;
                    end
                end
                default: armed_q <= 1'b0;
            endcase
        end
    end

    // Decide which registers a detected edge loads.
    always_comb begin
        a_we_o  = 1'b0;
        b_we_o  = 1'b0;
        a_val_o = hold_q;
        b_val_o = cnt_i;
        evt_o   = 1'b0;
        case (mode_i)
            MODE_PW: begin
                if (armed_q && opp_edge_i) begin
                    a_we_o = 1'b1;
                    b_we_o = 1'b1;
                    evt_o  = 1'b1;
                end
            end
            MODE_PER: begin
                if (armed_q && sel_edge_i) begin
                    a_we_o = 1'b1;
                    b_we_o = 1'b1;
                    evt_o  = 1'b1;
                end
            end
            MODE_IC: begin
                if (sel_edge_i) begin
                    b_we_o = 1'b1;
                    evt_o  = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tcc_compare.sv
// Compare and PWM engine. In the compare modes it matches the counter
// against A and B directly. In PWM it masks the counter to the selected
// resolution and uses copies of A and B that load at the period rollover.
// Assumes CNT_W >= 7.
module tcc_compare
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       mode_i,
    input  logic             res_hi_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] a_i,
    input  logic [CNT_W-1:0] b_i,
    output logic             pin_o,
    output logic             oe_o,
    output logic             evt_o
);
    logic             pwm, oc;
    logic [CNT_W-1:0] mask, cv, a_cmp, b_cmp;
    logic [CNT_W-1:0] a_act_q, b_act_q;
    logic             match_a, match_b, pin_q;
    int               bits;

    // Work out the mode class, the resolution mask and the match terms.
    always_comb begin
        pwm   = mode_i[3];
        oc    = (mode_i == MODE_OCB) || (mode_i == MODE_OCAB);
        oe_o  = pwm | oc;
        bits  = res_bits({res_hi_i, mode_i[1:0]});
        if (bits > CNT_W) bits = CNT_W;
        mask  = {CNT_W{1'b1}} >> (CNT_W - bits);
        cv    = pwm ? (cnt_i & mask) : cnt_i;
        a_cmp = pwm ? a_act_q : a_i;
        b_cmp = pwm ? b_act_q : b_i;
        match_a = oe_o && (cv == a_cmp);
        match_b = oe_o && (cv == b_cmp);
        evt_o   = match_b || ((mode_i == MODE_OCAB) && match_a);
        pin_o   = pin_q & oe_o;
    end

    // Load the active compare values at rollover in PWM, else track A and B.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_act_q <= '0;
            b_act_q <= '0;
        end else if (!pwm || (cv == mask)) begin
            a_act_q <= a_i;
            b_act_q <= b_i;
        end
    end

    // Drive the pin level from the matches, with B taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       pin_q <= 1'b0;
        else if (!oe_o)   pin_q <= 1'b0;
        else if (match_b) pin_q <= 1'b0;
        else if (match_a) pin_q <= 1'b1;
    end
endmodule

// File: rtl/dual_reg_timer_chan.sv
// Top of the dual-register capture/compare timer channel. It owns the
// control, A, B and flag registers and the register port, and joins the
// bus selector, pin synchronizer, capture and compare engines.
// Assumes NUM_BUSES <= 4 (the select field is two bits wide) and CNT_W >= 8.
module dual_reg_timer_chan
    import tcc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int NUM_BUSES   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_BUSES > 1) ? $clog2(NUM_BUSES) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_BUSES*CNT_W-1:0] cnt_bus_i,
    input  logic                       pin_i,
    output logic                       pin_o,
    output logic                       pin_oe_o,
    input  logic                       wr_en_i,
    input  logic [1:0]                 wr_addr_i,
    input  logic [CNT_W-1:0]           wr_data_i,
    input  logic [1:0]                 rd_addr_i,
    output logic [CNT_W-1:0]           rd_data_o,
    output logic                       flag_o,
    output logic                       pin_status_o
);
    logic [7:0]       ctl_q;
    logic [CNT_W-1:0] a_q, b_q, cnt;
    logic             flag_q;
    logic [3:0]       mode;
    logic             sel_edge, opp_edge;
    logic             cap_a_we, cap_b_we, cap_evt, cmp_evt;
    logic [CNT_W-1:0] cap_a_val, cap_b_val;
    logic             wr_ctl, wr_a, wr_b, wr_clr;

    // Decode register writes and the control fields.
    always_comb begin
        mode   = ctl_q[3:0];
        wr_ctl = wr_en_i && (wr_addr_i == ADDR_CTL);
        wr_a   = wr_en_i && (wr_addr_i == ADDR_A);
        wr_b   = wr_en_i && (wr_addr_i == ADDR_B);
        wr_clr = wr_en_i && (wr_addr_i == ADDR_STAT) && wr_data_i[0];
    end

    tcc_bus_sel #(.CNT_W(CNT_W), .NUM_BUSES(NUM_BUSES)) u_bus_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .bus_i (cnt_bus_i),
        .sel_i (ctl_q[4 +: SEL_W]),
        .cnt_o (cnt)
    );

    tcc_pin_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .fall_sel_i (ctl_q[6]),
        .level_o    (pin_status_o),
        .sel_edge_o (sel_edge),
        .opp_edge_o (opp_edge)
    );

    tcc_capture #(.CNT_W(CNT_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode),
        .sel_edge_i (sel_edge),
        .opp_edge_i (opp_edge),
        .cnt_i      (cnt),
        .a_we_o     (cap_a_we),
        .b_we_o     (cap_b_we),
        .a_val_o    (cap_a_val),
        .b_val_o    (cap_b_val),
        .evt_o      (cap_evt)
    );

    tcc_compare #(.CNT_W(CNT_W)) u_compare (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode),
        .res_hi_i (ctl_q[7]),
        .cnt_i    (cnt),
        .a_i      (a_q),
        .b_i      (b_q),
        .pin_o    (pin_o),
        .oe_o     (pin_oe_o),
        .evt_o    (cmp_evt)
    );

    // Control register: software write only.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_ctl) ctl_q <= wr_data_i[7:0];
    end

    // Register A: a capture overrides a software write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        a_q <= '0;
        else if (cap_a_we) a_q <= cap_a_val;
        else if (wr_a)     a_q <= wr_data_i;
    end

    // Register B: a capture overrides a software write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        b_q <= '0;
        else if (cap_b_we) b_q <= cap_b_val;
        else if (wr_b)     b_q <= wr_data_i;
    end

    // Sticky flag: set by events, cleared by W1C or by selecting disabled mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  flag_q <= 1'b0;
        else if (wr_ctl && wr_data_i[3:0] == MODE_DIS) flag_q <= 1'b0;
        else if (cap_evt || cmp_evt)                 flag_q <= 1'b1;
        else if (wr_clr)                             flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // Read multiplexer.
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            ADDR_CTL:  rd_data_o[7:0] = ctl_q;
            ADDR_A:    rd_data_o      = a_q;
            ADDR_B:    rd_data_o      = b_q;
            default:   rd_data_o[1:0] = {pin_status_o, flag_q};
        endcase
    end
endmodule

// File: rtl/tcc_chk.sv
// Assertion checker for the timer channel, bound to the top module.
module tcc_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   mode,
    input logic         pin_i,
    input logic         pin_o,
    input logic         pin_oe_o,
    input logic         pin_status_o,
    input logic         flag_o,
    input logic         wr_en_i,
    input logic [1:0]   wr_addr_i,
    input logic         wr_bit0,
    input logic [W-1:0] a_q
);
    logic [1:0] up_cnt;

    // Count cycles since reset so the sync check waits for valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)              up_cnt <= '0;
        else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
    end

    // R2
    dis_flag_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'b0000) |-> !flag_o);

    // R2
    input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[3] && mode != 4'b0100 && mode != 4'b0101) |-> (!pin_oe_o && !pin_o));

    // R2
    pin_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == 2'd3) |-> (pin_status_o == $past(pin_i, 2)));

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !(wr_en_i && wr_addr_i == 2'd0)
                && !(wr_en_i && wr_addr_i == 2'd3 && wr_bit0)) |=> flag_o);

    // R6
    ic_a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 4'b0011 && !(wr_en_i && wr_addr_i == 2'd1)) |=> $stable(a_q));
endmodule

bind dual_reg_timer_chan tcc_chk #(.W(CNT_W)) u_tcc_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (ctl_q[3:0]),
    .pin_i        (pin_i),
    .pin_o        (pin_o),
    .pin_oe_o     (pin_oe_o),
    .pin_status_o (pin_status_o),
    .flag_o       (flag_o),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_bit0      (wr_data_i[0]),
    .a_q          (a_q)
);

// File: tb/dual_reg_timer_chan_tb.sv
module dual_reg_timer_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus [4];
    logic [63:0] cnt_bus;
    logic        pin = 1'b0;
    logic        pin_o, pin_oe, flag, pin_st;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [15:0] wr_data = '0, rd_data;
    int          n_chk = 0, n_fail = 0;
    logic [15:0] rv;

    always #10 clk = ~clk;   // 50 MHz

    assign cnt_bus = {bus[3], bus[2], bus[1], bus[0]};

    dual_reg_timer_chan u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_bus_i(cnt_bus), .pin_i(pin),
        .pin_o(pin_o), .pin_oe_o(pin_oe), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .flag_o(flag), .pin_status_o(pin_st)
    );

    function automatic logic [15:0] exp_mask(input int idx);
        int n;
        case (idx)
            0: n = 7;   1: n = 9;   2: n = 11;  3: n = 12;
            4: n = 13;  5: n = 14;  6: n = 15;  default: n = 16;
        endcase
        return 16'((32'd1 << n) - 1);
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic set_pin(input logic v);
        pin = v;
        tick(4);
    endtask

    task automatic set_cnt(input int k, input logic [15:0] v);
        bus[k] = v;
        tick(3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] exp_a, mk, av, bv, hi;
        void'($urandom(32'd2024));
        for (int k = 0; k < 4; k++) bus[k] = 16'h0;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // reset state
        rd(2'd0, rv); chk("reset ctl", rv, 16'h0);
        rd(2'd1, rv); chk("reset A", rv, 16'h0);
        rd(2'd3, rv); chk("reset status", rv, 16'h0);
        chk("reset oe", {15'b0, pin_oe}, 16'h0);

        // R3: registers accessible while disabled
        wr(2'd0, 16'hFFB0); rd(2'd0, rv); chk("R3 ctl readback", rv, 16'h00B0);
        wr(2'd1, 16'h1234); rd(2'd1, rv); chk("R3 A readback", rv, 16'h1234);
        wr(2'd2, 16'hBEEF); rd(2'd2, rv); chk("R3 B readback", rv, 16'hBEEF);

        // R2: disabled ignores edges, pin status latency two edges
        bus[3] = 16'h5555;
        pin = 1'b1; tick(1);
        chk("R2 status after one edge", {15'b0, pin_st}, 16'h0);
        tick(1);
        chk("R2 status after two edges", {15'b0, pin_st}, 16'h1);
        set_pin(1'b0);
        rd(2'd1, rv); chk("R2 A untouched", rv, 16'h1234);
        rd(2'd2, rv); chk("R2 B untouched", rv, 16'hBEEF);
        chk("R2 flag low", {15'b0, flag}, 16'h0);
        chk("R2 oe low", {15'b0, pin_oe}, 16'h0);

        // R4: pulse width, rising leading edge, bus 1
        wr(2'd0, 16'h0000);
        bus[1] = 16'd1000;
        wr(2'd0, 16'h0011);
        set_pin(1'b1);
        rd(2'd1, rv); chk("R4 A unchanged on leading edge", rv, 16'h1234);
        chk("R4 no flag on leading edge", {15'b0, flag}, 16'h0);
        bus[1] = 16'd1500;
        set_pin(1'b0);
        rd(2'd1, rv); chk("R4 A leading count", rv, 16'd1000);
        rd(2'd2, rv); chk("R4 B trailing count", rv, 16'd1500);
        chk("R4 flag", {15'b0, flag}, 16'h1);

        // R11: mode write to disabled clears flag
        wr(2'd0, 16'h0000);
        chk("R11 flag cleared by disable", {15'b0, flag}, 16'h0);

        // R4 falling polarity: pin idles high
        set_pin(1'b1);
        bus[2] = 16'd40;
        wr(2'd0, 16'h0061);
        set_pin(1'b0);
        bus[2] = 16'd95;
        set_pin(1'b1);
        rd(2'd1, rv); chk("R4 falling A", rv, 16'd40);
        rd(2'd2, rv); chk("R4 falling B", rv, 16'd95);
        wr(2'd0, 16'h0000);
        set_pin(1'b0);

        // R5: period, falling edges, bus 0
        set_pin(1'b1);
        wr(2'd0, 16'h0042);
        bus[0] = 16'd300;
        set_pin(1'b0);
        chk("R5 no flag after first edge", {15'b0, flag}, 16'h0);
        bus[0] = 16'd500;
        set_pin(1'b1);
        chk("R5 rising edge ignored", {15'b0, flag}, 16'h0);
        bus[0] = 16'd700;
        set_pin(1'b0);
        rd(2'd1, rv); chk("R5 A first edge", rv, 16'd300);
        rd(2'd2, rv); chk("R5 B second edge", rv, 16'd700);
        chk("R5 flag", {15'b0, flag}, 16'h1);
        wr(2'd0, 16'h0000);

        // R1 + R6: random input capture on random buses and polarities
        exp_a = 16'd300;
        for (int it = 0; it < 10; it++) begin
            int s, p;
            s = $urandom % 4;
            p = $urandom % 2;
            for (int k = 0; k < 4; k++) bus[k] = 16'($urandom);
            wr(2'd0, 16'h0000);
            set_pin(p[0]);
            wr(2'd0, 16'((p << 6) | (s << 4) | 3));
            set_pin(~p[0]);
            rd(2'd2, rv); chk("R1 R6 capture from selected bus", rv, bus[s]);
            rd(2'd1, rv); chk("R6 A unchanged", rv, exp_a);
            chk("R6 flag", {15'b0, flag}, 16'h1);
        end
        wr(2'd0, 16'h0000);
        set_pin(1'b0);

        // R7 + R8: compare, flag on B only
        bus[0] = 16'd50;
        wr(2'd1, 16'd100); wr(2'd2, 16'd200);
        wr(2'd0, 16'h0004);
        tick(3);
        chk("R7 oe on", {15'b0, pin_oe}, 16'h1);
        chk("R7 pin low", {15'b0, pin_o}, 16'h0);
        set_cnt(0, 16'd100);
        chk("R7 pin high on A", {15'b0, pin_o}, 16'h1);
        chk("R8 no flag on A in B-only mode", {15'b0, flag}, 16'h0);
        set_cnt(0, 16'd200);
        chk("R7 pin low on B", {15'b0, pin_o}, 16'h0);
        chk("R8 flag on B", {15'b0, flag}, 16'h1);
        set_cnt(0, 16'd50);
        wr(2'd3, 16'h0001);
        chk("R11 W1C clears flag", {15'b0, flag}, 16'h0);
        tick(2);
        chk("R11 flag stays clear", {15'b0, flag}, 16'h0);

        // R8: flag on A in mode 0101; R7 B priority
        wr(2'd0, 16'h0005);
        set_cnt(0, 16'd100);
        chk("R8 flag on A in A/B mode", {15'b0, flag}, 16'h1);
        chk("R7 pin high", {15'b0, pin_o}, 16'h1);
        wr(2'd1, 16'd300); wr(2'd2, 16'd300);
        set_cnt(0, 16'd300);
        chk("R7 B wins on equal match", {15'b0, pin_o}, 16'h0);
        wr(2'd0, 16'h0000);

        // R9: PWM at random resolutions, with high bits outside the mask
        for (int it = 0; it < 10; it++) begin
            int idx;
            idx = (it < 8) ? it : int'($urandom % 8);
            mk = exp_mask(idx);
            av = 16'($urandom % {16'h0, mk});
            bv = 16'((av + 1 + ($urandom % ({16'h0, mk} - 1))) % {16'h0, mk});
            hi = 16'($urandom) & ~mk;
            wr(2'd0, 16'h0000);
            bus[0] = mk;
            wr(2'd1, av); wr(2'd2, bv);
            wr(2'd0, 16'(((idx >> 2) << 7) | 8 | (idx & 3)));
            tick(3);
            chk("R9 pwm starts low", {15'b0, pin_o}, 16'h0);
            set_cnt(0, hi | av);
            chk("R9 pwm high on masked A", {15'b0, pin_o}, 16'h1);
            set_cnt(0, hi | bv);
            chk("R9 pwm low on masked B", {15'b0, pin_o}, 16'h0);
        end
        wr(2'd0, 16'h0000);

        // R10: double buffering at 7-bit resolution
        bus[0] = 16'h007F;
        wr(2'd1, 16'h0010); wr(2'd2, 16'h0040);
        wr(2'd0, 16'h0008);
        set_cnt(0, 16'hAB10);
        chk("R10 high on initial A", {15'b0, pin_o}, 16'h1);
        set_cnt(0, 16'h0040);
        chk("R10 low on B", {15'b0, pin_o}, 16'h0);
        wr(2'd1, 16'h0020);
        set_cnt(0, 16'h0020);
        chk("R10 pending A not used", {15'b0, pin_o}, 16'h0);
        set_cnt(0, 16'h0010);
        chk("R10 old A still active", {15'b0, pin_o}, 16'h1);
        set_cnt(0, 16'h0040);
        set_cnt(0, 16'h007F);
        set_cnt(0, 16'h0020);
        chk("R10 new A after rollover", {15'b0, pin_o}, 16'h1);
        wr(2'd0, 16'h0000);
        tick(1);
        chk("R2 oe off after disable", {15'b0, pin_oe}, 16'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule